// File: doc/BRIEF.md
# Time-Aligned Clock-Out Generator

This block drives one general-purpose pin with a square wave whose edges fall on exact instants of a free-running scaled system-time counter. A typical use is a pulse-per-second output. The counter value comes in on a 64-bit input every clock. Software writes a 64-bit start instant and a 64-bit half-period through a word-wide write port. The half-period is the pulse length in the same scaled units, for example one second shifted left by the counter's fractional shift. Software then sets a small control register and a pin-configuration register. Software works out the aligned start instant itself.

While the output is armed, the block compares the system time against an internal next-edge register. When the time reaches or passes that value, the wave level flips and the next-edge register advances by exactly one period. The edges therefore stay on the target grid even if the time input jumps forward. The pin shows the wave only when the pin configuration selects output direction and the clock-out function. A one-cycle interrupt pulse marks each level flip when the interrupt bit is set. To reprogram the block, software clears the control register, writes the target and the period, and writes the control register last.

Top module: `tt_clkout_gen`

## Requirements
- R1: After reset, every register is zero, and pin_out, pin_oe and irq_pulse are low.
- R2: The write address map uses word addresses. Address 0 holds the target low word and address 1 the target high word. Address 2 holds the period low word and address 3 the period high word. Address 4 is the control register: bit 0 enable, bit 1 sync-to-time, bit 2 interrupt enable. Address 5 is the pin configuration: bit 0 output direction, bit 1 clock-out function select. Each write takes effect at the clock edge where wr_en is high.
- R3: The output is armed only when the enable and sync bits are both set. Once armed, the wave level stays low until the first clock edge at which systime is greater than or equal to the target. At that edge the level flips.
- R4: Each flip advances the next-edge instant by the current period value. Later flips therefore occur at target + k·period.
- R5: If systime jumps past several pending edges, the level flips once per clock until the next-edge instant passes systime again. The edge grid keeps its phase.
- R6: While not armed, the level is held low and no interrupt is raised. The next-edge instant is reloaded from the target register.
- R7: Target writes made while armed leave the running schedule unchanged. They take effect only after the output is disarmed and armed again.
- R8: pin_oe equals the direction bit. pin_out carries the wave level only when both the direction bit and the function-select bit are set, and is low otherwise.
- R9: irq_pulse is high for one cycle in the cycle after each level flip, and only when the interrupt-enable bit is set.
- R10: The time compare is a full 64-bit unsigned compare. A target whose high word is nonzero is not reached when only the low word of systime is at or above the target's low word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| systime | input | 64 | Running scaled system time |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address |
| wr_data | input | 32 | Register write data |
| pin_out | output | 1 | Pin output level |
| pin_oe | output | 1 | Pin output enable |
| irq_pulse | output | 1 | One-cycle interrupt pulse per level flip |

## Verification
A behavioural model of the edge schedule runs beside the design and is compared on every clock, while systime advances by one per clock, by large single jumps and by a steady step larger than the period. Steady stepping shows that the first edge waits for the target and that later edges are one period apart. Jumps and fast steps show catch-up flips and a grid that keeps its phase. A target placed just above a 32-bit boundary shows whether the compare uses all 64 bits. The pin-configuration combinations, the enable-without-sync case, and target writes made while armed separate gating faults from schedule faults.

// File: rtl/tt_clkout_pkg.sv
package tt_clkout_pkg;
   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_SYNC_BIT = 1;
   localparam int CTRL_IRQ_BIT  = 2;
   localparam int CFG_DIR_BIT   = 0;
   localparam int CFG_FUNC_BIT  = 1;

   typedef struct packed {
      logic irq_en;
      logic sync;
      logic en;
   } ctrl_t;

   typedef struct packed {
      logic func_sel;
      logic drive;
   } pincfg_t;
endpackage

// File: rtl/tt_clkout_regs.sv
module tt_clkout_regs
   import tt_clkout_pkg::*;
#(
   parameter int TIME_W = 64,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [TIME_W-1:0] target,
   output logic [TIME_W-1:0] period,
   output ctrl_t             ctrl,
   output pincfg_t           cfg
);
   localparam int NWORDS    = TIME_W / DATA_W;
   localparam int PER_BASE  = NWORDS;
   localparam int CTRL_ADDR = 2 * NWORDS;
   localparam int CFG_ADDR  = 2 * NWORDS + 1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         target <= '0;
         period <= '0;
         ctrl   <= '0;
         cfg    <= '0;
      end else if (wr_en) begin
         for (int w = 0; w < NWORDS; w++) begin
            if (wr_addr == ADDR_W'(w))
               target[w*DATA_W +: DATA_W] <= wr_data;
            if (wr_addr == ADDR_W'(PER_BASE + w))
               period[w*DATA_W +: DATA_W] <= wr_data;
         end
         if (wr_addr == ADDR_W'(CTRL_ADDR)) begin
            ctrl.en     <= wr_data[CTRL_EN_BIT];
            ctrl.sync   <= wr_data[CTRL_SYNC_BIT];
            ctrl.irq_en <= wr_data[CTRL_IRQ_BIT];
         end
         if (wr_addr == ADDR_W'(CFG_ADDR)) begin
            cfg.drive    <= wr_data[CFG_DIR_BIT];
            cfg.func_sel <= wr_data[CFG_FUNC_BIT];
         end
      end
   end
endmodule

// File: rtl/tt_clkout_sched.sv
module tt_clkout_sched #(
   parameter int TIME_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              armed,
   input  logic [TIME_W-1:0] systime,
   input  logic [TIME_W-1:0] target,
   input  logic [TIME_W-1:0] period,
   output logic              level,
   output logic              hit,
   output logic [TIME_W-1:0] next_edge
);
   assign hit = armed && (systime >= next_edge);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level     <= 1'b0;
         next_edge <= '0;
      end else if (!armed) begin
         level     <= 1'b0;
         next_edge <= target;
      end else if (hit) begin
         level     <= ~level;
         next_edge <= next_edge + period;
      end
   end
endmodule

// File: rtl/tt_clkout_pin.sv
module tt_clkout_pin
   import tt_clkout_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    level,
   input  logic    hit,
   input  logic    irq_en,
   input  pincfg_t cfg,
   output logic    pin_out,
   output logic    pin_oe,
   output logic    irq
);
   logic routed;
   assign routed = cfg.drive & cfg.func_sel;

   always_ff @(posedge clk) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= hit & irq_en;
   end

   generate
      if (OUT_REG) begin : g_reg_pin
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pin_out <= 1'b0;
               pin_oe  <= 1'b0;
            end else begin
               pin_out <= routed & level;
               pin_oe  <= cfg.drive;
            end
         end
      end else begin : g_comb_pin
         assign pin_out = routed & level;
         assign pin_oe  = cfg.drive;
      end
   endgenerate
endmodule

// File: rtl/tt_clkout_gen.sv
module tt_clkout_gen
   import tt_clkout_pkg::*;
#(
   parameter int TIME_W  = 64,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 3,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] systime,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              pin_out,
   output logic              pin_oe,
   output logic              irq_pulse
);
   localparam int NWORDS = TIME_W / DATA_W;
   localparam int NREGS  = 2 * NWORDS + 2;

   generate
      if (TIME_W % DATA_W != 0) begin : g_bad_width
         $error("TIME_W must be a multiple of DATA_W");
      end
      if ((1 << ADDR_W) < NREGS) begin : g_bad_addr
         $error("ADDR_W too narrow for register map");
      end
   endgenerate

   logic [TIME_W-1:0] target, period, next_edge;
   ctrl_t             ctrl;
   pincfg_t           cfg;
   logic              armed, level, hit;

   tt_clkout_regs #(.TIME_W(TIME_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .target(target), .period(period),
      .ctrl(ctrl), .cfg(cfg)
   );

   assign armed = ctrl.en & ctrl.sync;

   tt_clkout_sched #(.TIME_W(TIME_W)) u_sched (
      .clk(clk), .rst_n(rst_n), .armed(armed), .systime(systime),
      .target(target), .period(period), .level(level), .hit(hit),
      .next_edge(next_edge)
   );

   tt_clkout_pin #(.OUT_REG(OUT_REG)) u_pin (
      .clk(clk), .rst_n(rst_n), .level(level), .hit(hit),
      .irq_en(ctrl.irq_en), .cfg(cfg), .pin_out(pin_out),
      .pin_oe(pin_oe), .irq(irq_pulse)
   );
endmodule

// File: rtl/tt_clkout_chk.sv
module tt_clkout_chk #(
   parameter int TIME_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              armed,
   input logic              level,
   input logic [TIME_W-1:0] next_edge,
   input logic [TIME_W-1:0] period,
   input logic [TIME_W-1:0] systime,
   input logic              pin_out,
   input logic              pin_oe,
   input logic              irq
);
   // R6: a disarmed output drops to low on the next edge
   a_r6_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> !level);

   // R6: no interrupt follows a disarmed cycle
   a_r6_no_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> !irq);

   // R3: an armed flip only happens once time reached the edge
   a_r3_flip_needs_time: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(armed) && (level != $past(level))) |-> ($past(systime) >= $past(next_edge)));

   // R4: every armed flip moves the edge forward by one period
   a_r4_advance_by_period: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(armed) && (level != $past(level))) |-> (next_edge == $past(next_edge) + $past(period)));

   // R9: an interrupt pulse coincides with a level flip
   a_r9_irq_on_flip: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (level != $past(level)));

   // R8: the pin never shows a high level when not driven
   a_r8_out_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
      pin_out |-> pin_oe);
endmodule

bind tt_clkout_gen tt_clkout_chk #(.TIME_W(TIME_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .armed(armed), .level(level),
   .next_edge(next_edge), .period(period), .systime(systime),
   .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq_pulse)
);

// File: tb/tt_clkout_gen_bench.sv
`timescale 1ns/1ps
module tt_clkout_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] st;
   logic [63:0] st_inc = 64'd1;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        pin_out, pin_oe, irq_pulse;

   int    n_cmp = 0;
   int    n_bad = 0;
   string cur_req = "R1";
   bit    finished = 1'b0;

   always #4 clk = ~clk;

   tt_clkout_gen u_tt_clkout_gen (
      .clk(clk), .rst_n(rst_n), .systime(st), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .pin_out(pin_out),
      .pin_oe(pin_oe), .irq_pulse(irq_pulse)
   );

   always @(posedge clk) begin
      if (!rst_n) st <= 64'd0;
      else        st <= st + st_inc;
   end

   // Behavioural reference of the requirements
   logic [63:0] m_tgt, m_per, m_next;
   logic [2:0]  m_ctrl;
   logic [1:0]  m_cfg;
   logic        m_level, m_irq;
   bit          m_armed;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_tgt <= 0; m_per <= 0; m_next <= 0; m_ctrl <= 0; m_cfg <= 0;
         m_level <= 0; m_irq <= 0;
      end else begin
         m_armed = m_ctrl[0] && m_ctrl[1];
         if (!m_armed) begin
            m_level <= 1'b0;
            m_next  <= m_tgt;
            m_irq   <= 1'b0;
         end else if (st >= m_next) begin
            m_level <= ~m_level;
            m_next  <= m_next + m_per;
            m_irq   <= m_ctrl[2];
         end else begin
            m_irq   <= 1'b0;
         end
         if (wr_en) begin
            case (wr_addr)
               3'd0: m_tgt[31:0]  <= wr_data;
               3'd1: m_tgt[63:32] <= wr_data;
               3'd2: m_per[31:0]  <= wr_data;
               3'd3: m_per[63:32] <= wr_data;
               3'd4: m_ctrl       <= wr_data[2:0];
               3'd5: m_cfg        <= wr_data[1:0];
               default: ;
            endcase
         end
      end
   end

   task automatic check1(input string what, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s at %0t: actual=%0b expected=%0b", cur_req, what, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         check1("pin_oe",    pin_oe,    m_cfg[0]);
         check1("pin_out",   pin_out,   m_cfg[0] & m_cfg[1] & m_level);
         check1("irq_pulse", irq_pulse, m_irq);
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      idle(3);
      // R1: reset values on the ports
      check1("reset pin_out", pin_out, 1'b0);
      check1("reset pin_oe", pin_oe, 1'b0);
      check1("reset irq", irq_pulse, 1'b0);
      @(negedge clk) rst_n = 1'b1;
      idle(2);

      // R2 R3 R4: program and arm, first edge at 100, period 10
      cur_req = "R2 R3 R4";
      wr(3'd0, 32'd100); wr(3'd1, 32'd0);
      wr(3'd2, 32'd10);  wr(3'd3, 32'd0);
      wr(3'd5, 32'd3);   wr(3'd4, 32'd3);
      idle(150);

      // R9: interrupts on each flip
      cur_req = "R9";
      wr(3'd4, 32'd7);
      idle(60);

      // R8: pin configuration variants
      cur_req = "R8";
      wr(3'd5, 32'd1); idle(30);
      wr(3'd5, 32'd2); idle(30);
      wr(3'd5, 32'd0); idle(10);
      wr(3'd5, 32'd3); idle(20);

      // R7: target write while armed has no effect
      cur_req = "R7";
      wr(3'd0, 32'd5);
      idle(40);

      // R6: enable without sync, then fully off
      cur_req = "R6";
      wr(3'd4, 32'd5); idle(30);
      wr(3'd4, 32'd0); idle(20);
      wr(3'd0, st[31:0] + 32'd40);
      wr(3'd4, 32'd7); idle(80);

      // R5: time jumps past several edges, then fast stepping
      cur_req = "R5";
      @(negedge clk) st_inc = 64'd95;
      @(negedge clk) st_inc = 64'd1;
      idle(40);
      st_inc = 64'd25; idle(20);
      st_inc = 64'd1;  idle(60);

      // R10: target above a 32-bit boundary
      cur_req = "R10";
      wr(3'd4, 32'd0);
      wr(3'd0, 32'd0); wr(3'd1, 32'd1); wr(3'd2, 32'd16);
      @(negedge clk) st_inc = 64'h0000_0000_FFFF_FFD0 - st;
      @(negedge clk) st_inc = 64'd1;
      wr(3'd4, 32'd7);
      idle(150);

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule